// File: doc/BRIEF.md
# Predicated Consensus Branch Evaluator

This block turns one scalar branch comparison into a decision over a whole vector of element pairs. After a start strobe it walks the elements from index 0 upward, one per clock. Each element has an enable bit. An enabled element applies the selected comparison to its two operands, which arrive as a streamed pair in the matching cycle. The element's outcome goes into a per-element result mask. Disabled elements are skipped, leave a zero in the mask and do not count towards the decision.

When the walk ends, the tested outcomes are reduced under one of four consensus rules into a single taken or not-taken bit. A one-cycle done pulse marks that the decision and the mask are valid. Both then stay on the outputs until the next accepted start. With the early-exit option set, the walk stops at the first tested element whose outcome already settles the decision. Every later element is left untested with a zero in the mask.

Top module: `cbe_eval`

## Requirements
- R1: While reset is active, and after it until the first start, done_o, taken_o and result_o are all 0.
- R2: A start is accepted on a rising edge where start_i is 1 and the block is idle. Element k's operands are sampled on the (k+1)-th rising edge after the start edge. done_o is 1 for exactly the one cycle following the edge that processes the last element. With an element count of 0, that cycle is the one directly after the start edge.
- R3: cmp_sel_i selects the comparison of opa_i against opb_i: 00 equal, 01 not equal, 10 signed less-than, 11 signed greater-or-equal.
- R4: An element whose pred_i bit is 0 is not tested. Its result bit is 0 and it has no effect on the decision.
- R5: Bit k of result_o holds the comparison outcome of tested element k. Bits at index count or above are 0. result_o and taken_o keep their values from the done cycle until the next accepted start.
- R6: mode_i selects the consensus rule. 00: taken when no tested outcome is 1. 01: taken when every tested outcome is 1. 10: taken when at least one tested outcome is 0. 11: taken when at least one tested outcome is 1. With no tested element, 00 and 01 are taken and 10 and 11 are not.
- R7: With ffirst_i set, the walk ends after the first tested element whose outcome is 1 in modes 00 and 11, or 0 in modes 01 and 10. Later elements are not tested, their result bits are 0, and done_o follows that element.
- R8: A start strobe while a walk is in progress is ignored. The running walk's configuration, timing, mask and decision are unchanged.
- R9: A count_i value above the number of element slots is treated as the number of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for a new evaluation |
| count_i | input | CNT_W = $clog2(NUM_ELEM+1) | Number of elements to walk |
| pred_i | input | NUM_ELEM | Per-element enable bits, bit k for element k |
| cmp_sel_i | input | 2 | Comparison select (R3) |
| mode_i | input | 2 | Consensus rule select (R6) |
| ffirst_i | input | 1 | Early-exit enable (R7) |
| opa_i | input | DATA_W | First operand of the current element |
| opb_i | input | DATA_W | Second operand of the current element |
| result_o | output | NUM_ELEM | Per-element comparison result mask |
| taken_o | output | 1 | Branch decision |
| done_o | output | 1 | One-cycle pulse: decision and mask valid |

## Verification
An early exit and an ordinary end of walk meet in the same cycle: the element that settles the decision under early exit may also be the last element within the count. Both have to give the same single done pulse and the same mask. The bench provokes this by sweeping every enable pattern with every count, mode and comparison, with early exit on and off. It judges the latency of done_o, the mask and the decision against values computed arithmetically from population counts. A second collision is a start strobe that lands during a running walk. It is injected in the middle of a full-length walk, and the bench checks that the original result and timing are unchanged.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_LT = 2'b10,
    CMP_GE = 2'b11
  } cmp_sel_e;

  typedef enum logic [1:0] {
    CNS_NONE     = 2'b00,
    CNS_ALL      = 2'b01,
    CNS_SOMEZERO = 2'b10,
    CNS_ANY      = 2'b11
  } cns_mode_e;

  // Outcome value that settles the decision early under each rule
  function automatic logic settling_value(input cns_mode_e m);
    return (m == CNS_NONE) || (m == CNS_ANY);
  endfunction

endpackage

// File: rtl/cbe_cmp.sv
module cbe_cmp
  import cbe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cmp_sel_e          sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_o
);

  logic eq_w;
  logic lt_w;

  assign eq_w = (a_i == b_i);
  assign lt_w = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (sel_i)
      CMP_EQ:  res_o = eq_w;
      CMP_NE:  res_o = ~eq_w;
      CMP_LT:  res_o = lt_w;
      CMP_GE:  res_o = ~lt_w;
      default: res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbe_consensus.sv
module cbe_consensus
  import cbe_pkg::*;
(
  input  cns_mode_e mode_i,
  input  logic      seen_one_i,
  input  logic      seen_zero_i,
  input  logic      tested_i,
  input  logic      outcome_i,
  input  logic      ffirst_i,
  output logic      taken_o,
  output logic      stop_o
);

  always_comb begin
    unique case (mode_i)
      CNS_NONE:     taken_o = ~seen_one_i;
      CNS_ALL:      taken_o = ~seen_zero_i;
      CNS_SOMEZERO: taken_o = seen_zero_i;
      CNS_ANY:      taken_o = seen_one_i;
      default:      taken_o = 1'b0;
    endcase
  end

  assign stop_o = ffirst_i && tested_i && (outcome_i == settling_value(mode_i));

endmodule

// File: rtl/cbe_eval.sv
module cbe_eval
  import cbe_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  localparam int CNT_W   = $clog2(NUM_ELEM + 1),
  localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic [NUM_ELEM-1:0] pred_i,
  input  logic [1:0]          cmp_sel_i,
  input  logic [1:0]          mode_i,
  input  logic                ffirst_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  output logic [NUM_ELEM-1:0] result_o,
  output logic                taken_o,
  output logic                done_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // state
  logic                busy_q,  busy_d;
  logic [IDX_W-1:0]    idx_q,   idx_d;
  logic [CNT_W-1:0]    cnt_q,   cnt_d;
  logic [NUM_ELEM-1:0] en_q,    en_d;
  cmp_sel_e            sel_q,   sel_d;
  cns_mode_e           mode_q,  mode_d;
  logic                ff_q,    ff_d;
  logic                one_q,   one_d;
  logic                zero_q,  zero_d;
  logic [NUM_ELEM-1:0] res_q,   res_d;
  logic                done_q,  done_d;
  logic                taken_q, taken_d;

  // start acceptance and count clamp
  logic                start_acc;
  logic [CNT_W-1:0]    cnt_eff;
  logic [NUM_ELEM-1:0] lim_mask;

  assign start_acc = start_i && !busy_q;
  assign cnt_eff   = (count_i > CNT_W'(NUM_ELEM)) ? CNT_W'(NUM_ELEM) : count_i;

  for (genvar k = 0; k < NUM_ELEM; k++) begin : g_lim
    assign lim_mask[k] = (CNT_W'(k) < cnt_eff);
  end

  // current element
  logic cmp_res;
  logic elem_tested;
  logic last_elem;
  logic stop_early;
  logic cns_taken;
  logic one_nx;
  logic zero_nx;

  cbe_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sel_i (sel_q),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (cmp_res)
  );

  assign elem_tested = busy_q && en_q[idx_q];
  assign last_elem   = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
  assign one_nx      = start_acc ? 1'b0 : (one_q  | (elem_tested &  cmp_res));
  assign zero_nx     = start_acc ? 1'b0 : (zero_q | (elem_tested & ~cmp_res));

  cbe_consensus u_cns (
    .mode_i      (start_acc ? cns_mode_e'(mode_i) : mode_q),
    .seen_one_i  (one_nx),
    .seen_zero_i (zero_nx),
    .tested_i    (elem_tested),
    .outcome_i   (cmp_res),
    .ffirst_i    (ff_q),
    .taken_o     (cns_taken),
    .stop_o      (stop_early)
  );

  // next state
  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    en_d    = en_q;
    sel_d   = sel_q;
    mode_d  = mode_q;
    ff_d    = ff_q;
    one_d   = one_nx;
    zero_d  = zero_nx;
    res_d   = res_q;
    done_d  = 1'b0;
    taken_d = taken_q;
    if (start_acc) begin
      cnt_d  = cnt_eff;
      en_d   = pred_i & lim_mask;
      sel_d  = cmp_sel_e'(cmp_sel_i);
      mode_d = cns_mode_e'(mode_i);
      ff_d   = ffirst_i;
      idx_d  = '0;
      res_d  = '0;
      if (cnt_eff == '0) begin
        done_d  = 1'b1;
        taken_d = cns_taken;
      end else begin
        busy_d = 1'b1;
      end
    end else if (busy_q) begin
      if (elem_tested) begin
        res_d[idx_q] = cmp_res;
      end
      if (last_elem || stop_early) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        taken_d = cns_taken;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      en_q    <= '0;
      sel_q   <= CMP_EQ;
      mode_q  <= CNS_NONE;
      ff_q    <= 1'b0;
      one_q   <= 1'b0;
      zero_q  <= 1'b0;
      res_q   <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      en_q    <= en_d;
      sel_q   <= sel_d;
      mode_q  <= mode_d;
      ff_q    <= ff_d;
      one_q   <= one_d;
      zero_q  <= zero_d;
      res_q   <= res_d;
      done_q  <= done_d;
      taken_q <= taken_d;
    end
  end

  assign result_o = res_q;
  assign taken_o  = taken_q;
  assign done_o   = done_q;

  // assertions
  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |-> (CNT_W'(idx_q) < cnt_q));

  assert_done_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> !busy_q);

  assert_untested_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> ((res_q & ~en_q) == '0));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_q && !start_i) |=> ($stable(res_q) && $stable(taken_q)));

  assert_ffirst_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && ff_q && (mode_q == CNS_NONE || mode_q == CNS_ANY))
      |-> ($countones(res_q) <= 1));

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_q && start_i) |=> ($stable(mode_q) && $stable(en_q) && $stable(cnt_q) && $stable(sel_q)));

endmodule

// File: tb/cbe_eval_tb.sv
module cbe_eval_tb_top;

  localparam int N     = 4;
  localparam int DW    = 3;
  localparam int CNT_W = $clog2(N + 1);

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [CNT_W-1:0] count_i;
  logic [N-1:0]  pred_i;
  logic [1:0]    cmp_sel_i;
  logic [1:0]    mode_i;
  logic          ffirst_i;
  logic [DW-1:0] opa_i;
  logic [DW-1:0] opb_i;
  logic [N-1:0]  result_o;
  logic          taken_o;
  logic          done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  cbe_eval #(.NUM_ELEM(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .pred_i(pred_i), .cmp_sel_i(cmp_sel_i), .mode_i(mode_i), .ffirst_i(ffirst_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .taken_o(taken_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected <150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic ref_cmp(input logic [1:0] s, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (s)
      2'b00:   return a == b;
      2'b01:   return a != b;
      2'b10:   return $signed(a) < $signed(b);
      default: return !($signed(a) < $signed(b));
    endcase
  endfunction

  task automatic run(input int cnt, input logic [N-1:0] pr, input logic [1:0] sel,
                     input logic [1:0] md, input logic ff, input bit intrude);
    logic [DW-1:0] a [N];
    logic [DW-1:0] b [N];
    logic [N-1:0]  exp_mask;
    logic [N-1:0]  tested;
    logic          fixv;
    logic          exp_taken;
    logic [N-1:0]  hold_mask;
    logic          hold_taken;
    int eff, last, lat, got, n_t, n_r;
    string tg;
    for (int k = 0; k < N; k++) begin
      a[k] = DW'($urandom);
      b[k] = DW'($urandom);
    end
    eff = (cnt > N) ? N : cnt;
    fixv = (md == 2'b00) || (md == 2'b11);
    exp_mask = '0;
    tested = '0;
    last = eff - 1;
    for (int k = 0; k < eff; k++) begin
      if (pr[k]) begin
        tested[k] = 1'b1;
        exp_mask[k] = ref_cmp(sel, a[k], b[k]);
        if (ff && exp_mask[k] == fixv) begin
          last = k;
          break;
        end
      end
    end
    n_t = $countones(tested);
    n_r = $countones(exp_mask);
    case (md)
      2'b00:   exp_taken = (n_r == 0);
      2'b01:   exp_taken = (n_r == n_t);
      2'b10:   exp_taken = (n_r != n_t);
      default: exp_taken = (n_r != 0);
    endcase
    lat = last + 2;
    tg = ff ? "R7" : (cnt > N ? "R9" : (intrude ? "R8" : "R2"));

    @(negedge clk);
    start_i = 1'b1; count_i = CNT_W'(cnt); pred_i = pr;
    cmp_sel_i = sel; mode_i = md; ffirst_i = ff;
    got = 0;
    for (int c = 1; c <= N + 3; c++) begin
      @(negedge clk);
      start_i = intrude && (c == 2);
      if (start_i) begin
        mode_i = ~md; pred_i = ~pr; count_i = CNT_W'(N); ffirst_i = ~ff; cmp_sel_i = ~sel;
      end
      if (c - 1 < N) begin
        opa_i = a[c-1];
        opb_i = b[c-1];
      end
      if (done_o) begin
        got = c;
        break;
      end
    end
    chk(got == lat, {tg, " done latency"}, got, lat);
    chk(result_o == exp_mask, {tg, " R3 R4 R5 result mask"}, int'(result_o), int'(exp_mask));
    chk(taken_o == exp_taken, {tg, " R6 decision"}, int'(taken_o), int'(exp_taken));
    hold_mask = result_o;
    hold_taken = taken_o;
    start_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, {tg, " R2 single done pulse"}, int'(done_o), 0);
    chk(result_o == hold_mask && taken_o == hold_taken, {tg, " R5 hold after done"},
        int'({taken_o, result_o}), int'({hold_taken, hold_mask}));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; count_i = '0; pred_i = '0;
    cmp_sel_i = '0; mode_i = '0; ffirst_i = 1'b0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && taken_o == 1'b0 && result_o == '0, "R1 reset state",
        int'({done_o, taken_o, result_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0 && taken_o == 1'b0 && result_o == '0, "R1 after reset release",
        int'({done_o, taken_o, result_o}), 0);

    for (int cnt = 0; cnt < (1 << CNT_W); cnt++)
      for (int pr = 0; pr < (1 << N); pr++)
        for (int md = 0; md < 4; md++)
          for (int sel = 0; sel < 4; sel++)
            for (int ff = 0; ff < 2; ff++)
              run(cnt, N'(pr), 2'(sel), 2'(md), 1'(ff), (cnt == N) && (ff == 0) && (sel == md));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule